// File: doc/BRIEF.md
# Software-Refilled Translation Lookaside Buffer

This block turns 32-bit virtual addresses into 30-bit physical addresses for 4 KB pages. It holds a small table of page mappings and compares every tag in parallel. Hit, miss, modify-fault, physical address and permission bits all settle combinationally, in the same cycle as the lookup. The 12 offset bits pass through unchanged, and the 20-bit virtual page number is replaced by an 18-bit physical page number. The lookup side has no back-pressure. A lookup is presented by holding `lk_req` high for one cycle, and it is always accepted, so there is no ready signal.

The table is filled by software, not by a hardware table walker. Software stages a mapping in two holding registers: a page register and a frame register that holds the physical page and the flags. It then issues one of two commands. An indexed write stores the mapping at the slot named by the slot-pointer register. A random write stores it at the slot named by a free-running victim counter. An indexed read copies a table slot back into the two holding registers.

When a lookup misses or raises a modify fault, the virtual address is latched into a fault-address register. A page-table pointer register combines a software-written table base with the faulting page number. A refill handler can use it directly as the address of the page-table entry.

Top module: `tlb_sw`

## Requirements
- R1: On a hit, `lk_paddr` equals the matching entry's 18-bit physical page number in bits 29..12, concatenated with `lk_vaddr[11:0]`. `lk_perm` gives that entry's permission bits.
- R2: During a cycle with `lk_req` high, exactly one of `lk_hit` and `lk_miss` is high, decided combinationally in that cycle. With `lk_req` low, `lk_hit`, `lk_miss` and `lk_mod_fault` are all low.
- R3: After a cycle in which `lk_miss` or `lk_mod_fault` is high, the fault-address register (select 4) holds that cycle's `lk_vaddr`. The page-table pointer register (select 5) reads as {base[31:22], faulting VPN in [21:2], 2'b00}, and only the base field is writable.
- R4: `cmd_wr_idx` writes the page register (select 0, VPN in bits 31:12) and the frame register into the slot given by the slot-pointer register (select 2, low 4 bits). The frame register is select 1, with PPN in [29:12], valid in [4], dirty in [3], reference in [2] and permission in [1:0]. `cmd_rd_idx` copies that slot back into both holding registers.
- R5: `cmd_wr_rnd` writes the holding registers into the slot whose number the victim counter (select 3) shows in that same cycle.
- R6: The victim counter resets to 15 and steps down by one every cycle. From the wired lower bound (default 0) it returns to 15, so it never leaves the range from that bound to 15.
- R7: If several valid entries match the page number, the lowest-numbered one supplies the translation.
- R8: A lookup with `lk_store` high that hits an entry whose dirty bit is 0 raises `lk_mod_fault` while still reporting the hit. A load, or a store to a dirty entry, raises no modify fault.
- R9: Every hit sets the reference bit of the matching entry. An indexed read of that slot afterwards shows frame-register bit 2 set.
- R10: Reset clears every valid bit, so every lookup misses until a slot is written.
- R11: A lookup in the same cycle as a write to the slot it would match is not reported as a hit from that slot.
- R12: Software writes to the fault-address register and to the victim counter are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_store | input | 1 | Lookup is a store (1) or a load (0) |
| lk_paddr | output | 30 | Translated physical address (0 when no hit) |
| lk_perm | output | 2 | Permission bits of the hit entry |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | No translation found |
| lk_mod_fault | output | 1 | Store hit a clean page |
| sw_sel | input | 3 | Register select: 0 page, 1 frame, 2 slot pointer, 3 victim, 4 fault address, 5 table pointer |
| sw_we | input | 1 | Write sw_wdata to the selected register |
| sw_wdata | input | 32 | Register write data |
| sw_rdata | output | 32 | Selected register contents, combinational |
| cmd_wr_idx | input | 1 | Write holding registers to the slot named by the slot pointer |
| cmd_wr_rnd | input | 1 | Write holding registers to the victim slot |
| cmd_rd_idx | input | 1 | Read the pointed slot into the holding registers |

## Verification
On every cycle the assertions check the following:
- hit and miss are exclusive, and the outputs stay quiet when no request is present;
- the page offset passes through on a hit;
- the fault address is captured after each fault and is held otherwise;
- the victim counter's range, its step and its wrap;
- a slot being written never supplies a hit;
- a modify fault always comes with a store hit.

Only the bench scenarios can show the rest. These are the translated page numbers, lowest-slot priority among duplicate tags, the reference bit set by a hit, the round trip from write to indexed read, random-slot placement, the page-table pointer layout, and the ignoring of writes to the read-only registers.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 30;
  localparam int OFF_W  = 12;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int PERM_W = 2;
  localparam int BASE_W = 10;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic              dirty;
    logic              refd;
    logic [PERM_W-1:0] perm;
  } tlb_entry_t;

  typedef enum logic [2:0] {
    SEL_PAGE  = 3'd0,
    SEL_FRAME = 3'd1,
    SEL_SLOT  = 3'd2,
    SEL_VICT  = 3'd3,
    SEL_FAULT = 3'd4,
    SEL_TABLE = 3'd5
  } sw_sel_e;
endpackage

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 16,
  parameter int WIRED = 0,
  parameter int IW    = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [IW-1:0] victim
);
  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_q <= IW'(N - 1);
    else if (cnt_q == IW'(WIRED))   cnt_q <= IW'(N - 1);
    else                            cnt_q <= cnt_q - IW'(1);
  end

  assign victim = cnt_q;
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N  = 16,
  parameter int IW = $clog2(N),
  parameter int TW = 20
) (
  input  logic [N-1:0]         valid_v,
  input  logic [N-1:0][TW-1:0] tag_v,
  input  logic [TW-1:0]        tag,
  input  logic                 skip_en,
  input  logic [IW-1:0]        skip_idx,
  output logic                 hit,
  output logic [IW-1:0]        hit_idx
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = valid_v[g] && (tag_v[g] == tag) &&
                   !(skip_en && (skip_idx == IW'(g)));
  end

  // scan downward so the lowest matching slot is the last one kept
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IW-1:0]         wr_idx,
  input  tlb_entry_t            wr_ent,
  input  logic                  ref_en,
  input  logic [IW-1:0]         ref_idx,
  output tlb_entry_t [N-1:0]    ents
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    tlb_entry_t e_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                               e_q <= '0;
      else if (wr_en && (wr_idx == IW'(g)))     e_q <= wr_ent;
      else if (ref_en && (ref_idx == IW'(g)))   e_q.refd <= 1'b1;
    end
    assign ents[g] = e_q;
  end
endmodule

// File: rtl/tlb_sw.sv
module tlb_sw
  import tlb_pkg::*;
#(
  parameter  int ENTRIES = 16,
  parameter  int WIRED   = 0,
  localparam int IW      = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_store,
  output logic [PA_W-1:0]  lk_paddr,
  output logic [PERM_W-1:0] lk_perm,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic             lk_mod_fault,
  input  logic [2:0]       sw_sel,
  input  logic             sw_we,
  input  logic [31:0]      sw_wdata,
  output logic [31:0]      sw_rdata,
  input  logic             cmd_wr_idx,
  input  logic             cmd_wr_rnd,
  input  logic             cmd_rd_idx
);
  // software-visible holding registers
  logic [VPN_W-1:0]  page_q;
  logic [PPN_W-1:0]  fr_ppn_q;
  logic              fr_v_q, fr_d_q, fr_r_q;
  logic [PERM_W-1:0] fr_p_q;
  logic [IW-1:0]     slot_q;
  logic [VA_W-1:0]   fault_q;
  logic [BASE_W-1:0] base_q;

  logic [IW-1:0]     victim;
  tlb_entry_t [ENTRIES-1:0] ents;
  tlb_entry_t        wr_ent;
  tlb_entry_t        hit_ent;
  tlb_entry_t        rd_ent;
  logic              wr_en;
  logic [IW-1:0]     wr_idx;
  logic              m_hit;
  logic [IW-1:0]     m_idx;
  logic [ENTRIES-1:0]            valid_v;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_v;
  logic              fault_now;
  logic              unused_wdata;

  assign unused_wdata = ^sw_wdata;

  tlb_victim #(.N(ENTRIES), .WIRED(WIRED), .IW(IW)) u_victim (
    .clk(clk), .rst_n(rst_n), .victim(victim)
  );

  assign wr_en  = cmd_wr_idx | cmd_wr_rnd;
  assign wr_idx = cmd_wr_idx ? slot_q : victim;

  always_comb begin
    wr_ent       = '0;
    wr_ent.valid = fr_v_q;
    wr_ent.vpn   = page_q;
    wr_ent.ppn   = fr_ppn_q;
    wr_ent.dirty = fr_d_q;
    wr_ent.refd  = fr_r_q;
    wr_ent.perm  = fr_p_q;
  end

  tlb_array #(.N(ENTRIES), .IW(IW)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_ent(wr_ent),
    .ref_en(lk_hit), .ref_idx(m_idx),
    .ents(ents)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_tags
    assign valid_v[g] = ents[g].valid;
    assign tag_v[g]   = ents[g].vpn;
  end

  tlb_match #(.N(ENTRIES), .IW(IW), .TW(VPN_W)) u_match (
    .valid_v(valid_v), .tag_v(tag_v), .tag(lk_vaddr[VA_W-1:OFF_W]),
    .skip_en(wr_en), .skip_idx(wr_idx),
    .hit(m_hit), .hit_idx(m_idx)
  );

  // same-cycle lookup result
  assign hit_ent      = ents[m_idx];
  assign lk_hit       = lk_req & m_hit;
  assign lk_miss      = lk_req & ~m_hit;
  assign lk_mod_fault = lk_hit & lk_store & ~hit_ent.dirty;
  assign lk_paddr     = lk_hit ? {hit_ent.ppn, lk_vaddr[OFF_W-1:0]} : '0;
  assign lk_perm      = lk_hit ? hit_ent.perm : '0;
  assign fault_now    = lk_miss | lk_mod_fault;
  assign rd_ent       = ents[slot_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q   <= '0;
      fr_ppn_q <= '0;
      fr_v_q   <= 1'b0;
      fr_d_q   <= 1'b0;
      fr_r_q   <= 1'b0;
      fr_p_q   <= '0;
      slot_q   <= '0;
      fault_q  <= '0;
      base_q   <= '0;
    end else begin
      if (fault_now) fault_q <= lk_vaddr;
      if (cmd_rd_idx) begin
        page_q   <= rd_ent.vpn;
        fr_ppn_q <= rd_ent.ppn;
        fr_v_q   <= rd_ent.valid;
        fr_d_q   <= rd_ent.dirty;
        fr_r_q   <= rd_ent.refd;
        fr_p_q   <= rd_ent.perm;
      end else if (sw_we) begin
        case (sw_sel)
          SEL_PAGE:  page_q <= sw_wdata[31:OFF_W];
          SEL_FRAME: begin
            fr_ppn_q <= sw_wdata[PA_W-1:OFF_W];
            fr_v_q   <= sw_wdata[4];
            fr_d_q   <= sw_wdata[3];
            fr_r_q   <= sw_wdata[2];
            fr_p_q   <= sw_wdata[1:0];
          end
          default: ;
        endcase
      end
      if (sw_we && (sw_sel == SEL_SLOT))  slot_q <= sw_wdata[IW-1:0];
      if (sw_we && (sw_sel == SEL_TABLE)) base_q <= sw_wdata[31:32-BASE_W];
    end
  end

  always_comb begin
    case (sw_sel)
      SEL_PAGE:  sw_rdata = {page_q, {OFF_W{1'b0}}};
      SEL_FRAME: sw_rdata = {{(32-PA_W){1'b0}}, fr_ppn_q, 7'd0,
                             fr_v_q, fr_d_q, fr_r_q, fr_p_q};
      SEL_SLOT:  sw_rdata = {{(32-IW){1'b0}}, slot_q};
      SEL_VICT:  sw_rdata = {{(32-IW){1'b0}}, victim};
      SEL_FAULT: sw_rdata = fault_q;
      SEL_TABLE: sw_rdata = {base_q, fault_q[VA_W-1:OFF_W], 2'b00};
      default:   sw_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tlb_sw_chk.sv
module tlb_sw_chk #(
  parameter  int ENTRIES = 16,
  parameter  int WIRED   = 0,
  localparam int IW      = $clog2(ENTRIES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_req,
  input logic [31:0]   lk_vaddr,
  input logic          lk_store,
  input logic [29:0]   lk_paddr,
  input logic          lk_hit,
  input logic          lk_miss,
  input logic          lk_mod_fault,
  input logic [IW-1:0] victim,
  input logic [31:0]   fault_q,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic [IW-1:0] m_idx
);
  p_hit_miss_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |-> (lk_hit ^ lk_miss));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |-> (!lk_hit && !lk_miss && !lk_mod_fault));

  p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[11:0] == lk_vaddr[11:0]));

  p_fault_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_miss || lk_mod_fault) |=> (fault_q == $past(lk_vaddr)));

  p_fault_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_miss || lk_mod_fault) |=> $stable(fault_q));

  p_victim_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(victim) >= WIRED) && (int'(victim) <= ENTRIES - 1));

  p_victim_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(victim) != WIRED) |=> (victim == $past(victim) - IW'(1)));

  p_victim_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(victim) == WIRED) |=> (int'(victim) == ENTRIES - 1));

  p_no_hit_written_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lk_hit) |-> (m_idx != wr_idx));

  p_mod_fault_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_mod_fault |-> (lk_hit && lk_store));
endmodule

bind tlb_sw tlb_sw_chk #(.ENTRIES(ENTRIES), .WIRED(WIRED)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
  .lk_store(lk_store), .lk_paddr(lk_paddr), .lk_hit(lk_hit),
  .lk_miss(lk_miss), .lk_mod_fault(lk_mod_fault), .victim(victim),
  .fault_q(fault_q), .wr_en(wr_en), .wr_idx(wr_idx), .m_idx(m_idx)
);

// File: tb/tlb_sw_bench.sv
module tlb_sw_bench;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_store = 1'b0;
  logic [29:0] lk_paddr;
  logic [1:0]  lk_perm;
  logic        lk_hit, lk_miss, lk_mod_fault;
  logic [2:0]  sw_sel = '0;
  logic        sw_we = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;
  logic        cmd_wr_idx = 1'b0, cmd_wr_rnd = 1'b0, cmd_rd_idx = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tlb_sw u_tlb_sw (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
    .lk_store(lk_store), .lk_paddr(lk_paddr), .lk_perm(lk_perm),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_mod_fault(lk_mod_fault),
    .sw_sel(sw_sel), .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .cmd_wr_idx(cmd_wr_idx), .cmd_wr_rnd(cmd_wr_rnd), .cmd_rd_idx(cmd_rd_idx)
  );

  // reference model of the table
  logic        m_v   [N];
  logic [19:0] m_vpn [N];
  logic [17:0] m_ppn [N];
  logic        m_d   [N];
  logic        m_r   [N];
  logic [1:0]  m_p   [N];
  logic [31:0] m_fault;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit model_find(input logic [19:0] vpn, output int idx);
    idx = 0;
    for (int i = N - 1; i >= 0; i--)
      if (m_v[i] && m_vpn[i] == vpn) idx = i;
    return m_v[idx] && m_vpn[idx] == vpn;
  endfunction

  function automatic logic [31:0] frame_word(input logic [17:0] ppn, input logic v,
                                             input logic d, input logic r,
                                             input logic [1:0] p);
    return {2'b00, ppn, 7'd0, v, d, r, p};
  endfunction

  task automatic sw_wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    sw_sel = sel; sw_wdata = d; sw_we = 1'b1;
    @(posedge clk); #1;
    sw_we = 1'b0;
  endtask

  task automatic sw_rd(input logic [2:0] sel, output logic [31:0] d);
    @(negedge clk);
    sw_sel = sel;
    #1 d = sw_rdata;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    cmd_wr_idx = (which == 0); cmd_wr_rnd = (which == 1); cmd_rd_idx = (which == 2);
    @(posedge clk); #1;
    cmd_wr_idx = 1'b0; cmd_wr_rnd = 1'b0; cmd_rd_idx = 1'b0;
  endtask

  task automatic stage(input logic [19:0] vpn, input logic [17:0] ppn, input logic v,
                       input logic d, input logic r, input logic [1:0] p);
    sw_wr(3'd0, {vpn, 12'd0});
    sw_wr(3'd1, frame_word(ppn, v, d, r, p));
  endtask

  task automatic load(input int idx, input logic [19:0] vpn, input logic [17:0] ppn,
                      input logic v, input logic d, input logic r, input logic [1:0] p);
    sw_wr(3'd2, 32'(idx));
    stage(vpn, ppn, v, d, r, p);
    pulse(0);
    m_v[idx] = v; m_vpn[idx] = vpn; m_ppn[idx] = ppn;
    m_d[idx] = d; m_r[idx] = r; m_p[idx] = p;
  endtask

  task automatic lookup(input logic [31:0] va, input logic st, input string tag);
    int  idx;
    bit  eh;
    logic [29:0] epa;
    logic emf;
    @(negedge clk);
    lk_req = 1'b1; lk_vaddr = va; lk_store = st;
    #1;
    eh  = model_find(va[31:12], idx);
    epa = eh ? {m_ppn[idx], va[11:0]} : 30'd0;
    emf = eh && st && !m_d[idx];
    check(lk_hit == eh && lk_miss == !eh, {tag, " R2 hit/miss"},
          {30'd0, lk_hit, lk_miss}, {30'd0, eh, !eh});
    check(lk_paddr == epa, {tag, " R1 paddr"}, {2'b0, lk_paddr}, {2'b0, epa});
    if (eh) check(lk_perm == m_p[idx], {tag, " R1 perm"}, {30'd0, lk_perm}, {30'd0, m_p[idx]});
    check(lk_mod_fault == emf, {tag, " R8 modify fault"}, {31'd0, lk_mod_fault}, {31'd0, emf});
    @(posedge clk); #1;
    lk_req = 1'b0; lk_store = 1'b0;
    if (eh) m_r[idx] = 1'b1;
    if (!eh || emf) m_fault = va;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, prev, vict;
    logic [19:0] vp;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_d[i] = 0; m_r[i] = 0; m_p[i] = 0;
    end
    m_fault = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 / R6: reset state
    sw_rd(3'd3, rd);
    check(rd == 32'd15 || rd == 32'd14, "R6 victim after reset", rd, 32'd15);
    sw_rd(3'd4, rd);
    check(rd == 32'd0, "R10 fault register reset", rd, 32'd0);
    lookup(32'h0000_0123, 1'b0, "R10 empty table");
    lookup(32'hFFFF_F000, 1'b1, "R10 empty table");

    // R6: step and wrap over more than two periods
    sw_rd(3'd3, prev);
    for (int k = 0; k < 40; k++) begin
      sw_rd(3'd3, rd);
      check(rd == ((prev == 0) ? 32'd15 : prev - 1), "R6 victim step", rd,
            (prev == 0) ? 32'd15 : prev - 1);
      prev = rd;
    end

    // R4: fill every slot with unique tags
    for (int i = 0; i < N; i++)
      load(i, {$urandom_range(0, 65535) & 16'hffff, 4'(i)}, 18'($urandom),
           (i % 5) != 4, 1'($urandom), 1'b0, 2'($urandom));
    sw_wr(3'd2, 32'd6);
    pulse(2);
    sw_rd(3'd0, rd);
    check(rd == {m_vpn[6], 12'd0}, "R4 indexed read page", rd, {m_vpn[6], 12'd0});
    sw_rd(3'd1, rd);
    check(rd == frame_word(m_ppn[6], m_v[6], m_d[6], m_r[6], m_p[6]),
          "R4 indexed read frame", rd, frame_word(m_ppn[6], m_v[6], m_d[6], m_r[6], m_p[6]));

    // random lookups against the model
    for (int k = 0; k < 300; k++) begin
      int s = $urandom_range(0, N - 1);
      vp = ($urandom_range(0, 9) < 7) ? m_vpn[s] : 20'($urandom);
      lookup({vp, 12'($urandom)}, 1'($urandom), "rand");
      if (k % 10 == 0) begin
        sw_rd(3'd4, rd);
        check(rd == m_fault, "R3 fault address", rd, m_fault);
      end
    end

    // R9: reference bit set by a hit
    load(7, 20'hABCDE, 18'h1234, 1'b1, 1'b1, 1'b0, 2'd2);
    lookup(32'hABCD_E555, 1'b0, "R9 hit");
    sw_wr(3'd2, 32'd7);
    pulse(2);
    sw_rd(3'd1, rd);
    check(rd[2] == 1'b1, "R9 reference bit", {31'd0, rd[2]}, 32'd1);

    // R7: duplicate tags, lowest slot wins
    load(9, 20'h5A5A5, 18'h3_0009, 1'b1, 1'b1, 1'b0, 2'd1);
    load(3, 20'h5A5A5, 18'h3_0003, 1'b1, 1'b1, 1'b0, 2'd3);
    lookup(32'h5A5A_5ABC, 1'b0, "R7 priority");
    check(m_ppn[3] == 18'h3_0003, "R7 model slot", {14'd0, m_ppn[3]}, 32'h3_0003);

    // R8: directed modify-fault cases
    load(11, 20'h77777, 18'h0_0777, 1'b1, 1'b0, 1'b0, 2'd0);
    lookup(32'h7777_7010, 1'b1, "R8 store clean");
    sw_rd(3'd4, rd);
    check(rd == 32'h7777_7010, "R3 fault address after modify fault", rd, 32'h7777_7010);
    lookup(32'h7777_7010, 1'b0, "R8 load clean");
    load(11, 20'h77777, 18'h0_0777, 1'b1, 1'b1, 1'b0, 2'd0);
    lookup(32'h7777_7010, 1'b1, "R8 store dirty");

    // R3: page-table pointer layout
    sw_wr(3'd5, 32'hC040_0000);
    lookup(32'h1357_9ACE, 1'b0, "R3 miss");
    sw_rd(3'd5, rd);
    check(rd == {10'h301, 20'h13579, 2'b00}, "R3 table pointer", rd,
          {10'h301, 20'h13579, 2'b00});

    // R12: read-only registers ignore writes
    sw_wr(3'd4, 32'hDEAD_BEEF);
    sw_rd(3'd4, rd);
    check(rd == 32'h1357_9ACE, "R12 fault register write ignored", rd, 32'h1357_9ACE);
    sw_rd(3'd3, prev);
    sw_wr(3'd3, 32'd0);
    sw_rd(3'd3, rd);
    check(rd == ((prev + 32'd14) % 32'd16), "R12 victim write ignored", rd,
          (prev + 32'd14) % 32'd16);

    // R11: lookup during a write to the slot it matches
    load(5, 20'h2468A, 18'h0_0005, 1'b1, 1'b1, 1'b0, 2'd1);
    sw_wr(3'd2, 32'd5);
    stage(20'h2468A, 18'h0_0F05, 1'b1, 1'b1, 1'b0, 2'd1);
    @(negedge clk);
    lk_req = 1'b1; lk_vaddr = 32'h2468_A004; cmd_wr_idx = 1'b1;
    #1;
    check(lk_hit == 1'b0 && lk_miss == 1'b1, "R11 no hit on written slot",
          {30'd0, lk_hit, lk_miss}, 32'd1);
    @(posedge clk); #1;
    lk_req = 1'b0; cmd_wr_idx = 1'b0;
    m_ppn[5] = 18'h0_0F05; m_fault = 32'h2468_A004;
    lookup(32'h2468_A004, 1'b0, "R11 after write");

    // R5: random-slot write lands at the victim shown in that cycle
    stage(20'h0BEEF, 18'h2_BEEF, 1'b1, 1'b1, 1'b0, 2'd2);
    @(negedge clk);
    sw_sel = 3'd3;
    #1 vict = sw_rdata;
    cmd_wr_rnd = 1'b1;
    @(posedge clk); #1;
    cmd_wr_rnd = 1'b0;
    m_v[vict] = 1; m_vpn[vict] = 20'h0BEEF; m_ppn[vict] = 18'h2_BEEF;
    m_d[vict] = 1; m_r[vict] = 0; m_p[vict] = 2'd2;
    sw_wr(3'd2, vict);
    pulse(2);
    sw_rd(3'd0, rd);
    check(rd == 32'h0BEE_F000, "R5 random slot page", rd, 32'h0BEE_F000);
    lookup(32'h0BEE_F321, 1'b0, "R5 random slot hit");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule